// File: doc/BRIEF.md
# Virtual Output Queue Crossbar Scheduler

This block is the central arbiter for an N-by-N input-buffered crossbar. Each input keeps one queue per output. Every cycle, each input reports which of its per-output queues hold at least one cell. Because requests are kept per output, a busy destination cannot hold up cells bound for other outputs. Time is divided into fixed-size cell slots. The slot controller raises `slot_go` on the cycle in which the next slot's configuration must be computed.

On that cycle the scheduler builds a conflict-free pairing of inputs to outputs from the request matrix. It uses a fixed number of round-robin request/grant/accept passes, which approximates a maximum matching. The result is registered and drives two things: the crossbar (one input-select field per output) and the dequeue grants back to the inputs (one output number per input). Both hold unchanged until the next `slot_go`.

All pins are plain control levels sampled on the rising clock edge. There is no handshake: the request matrix is level status, and the slot configuration is consumed for a whole slot.

Top module: `vs_sched`

## Requirements
- R1: Bit `req[i*N+j]` means input i has at least one cell queued for output j. A lone request of pair (i,j) yields `xbar_en[j]=1`, `xbar_sel[j]=i`, `deq_vld[i]=1` and `deq_port[i]=j`, and every other enable is low.
- R2: A new pairing is computed only in a cycle with `slot_go=1`. It is visible from the cycle after that edge. While `slot_go=0`, all outputs and arbiter pointers hold their values whatever the requests do.
- R3: Each output is driven by at most one input and each input is granted at most one output. For every enabled output j whose `xbar_sel[j]` is i, `deq_vld[i]=1` and `deq_port[i]=j`.
- R4: A pair is connected only if its request bit was set in the `slot_go` cycle that produced it.
- R5: With ITERS at least N, the pairing is maximal: no unconnected input and unconnected output share a set request bit.
- R6: In each pass, every still-free output grants the first still-free requesting input found searching upward from its grant pointer, wrapping at N.
- R7: In each pass, every still-free input accepts the first granting output found searching upward from its accept pointer, wrapping at N.
- R8: Pointers move only for pairs accepted in the first pass. The output's grant pointer becomes (input+1) mod N and the input's accept pointer becomes (output+1) mod N. Pairs added in later passes leave pointers alone.
- R9: Passes after the first consider only inputs and outputs left free by the earlier passes of the same slot.
- R10: After reset, all pointers are zero and `xbar_en` and `deq_vld` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_go | input | 1 | Compute and load the configuration for the next slot |
| req | input | N*N | Non-empty flags of the per-output queues, bit i*N+j for input i, output j |
| xbar_en | output | N | Output j is connected for this slot |
| xbar_sel | output | N*log2(N) | Per output, the input number it takes cells from |
| deq_vld | output | N | Input i may dequeue one cell this slot |
| deq_port | output | N*log2(N) | Per input, the output whose queue it dequeues |

## Verification
The assertions check four properties on every cycle:
- the registered pairing has at most one connection per row and per column;
- a new pairing only connects requested pairs;
- state is frozen between slots;
- when enough passes run, no free request is left over after the last pass.

The exact choice among many legal pairings is shown only by the bench's scenarios. The bench sweeps every request pattern of a four-port instance back to back, so the round-robin pointers drift through many states, and compares each slot against an arithmetic model. That comparison is what shows the grant and accept orders, the first-pass-only pointer rule and the restriction of later passes to free ports.

// File: rtl/vs_pkg.sv
package vs_pkg;

  // modular increment used by arbiters and pointer updates
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned n);
    int unsigned s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/vs_rr_arb.sv
module vs_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  gnt
);
  logic [IW-1:0] pos;
  logic          hit;

  // first set request at or above ptr, wrapping
  always_comb begin
    gnt = '0;
    hit = 1'b0;
    pos = '0;
    for (int k = 0; k < N; k++) begin
      pos = IW'(vs_pkg::wrap_add(int'(ptr), k, N));
      if (!hit && req[pos]) begin
        hit      = 1'b1;
        gnt[pos] = 1'b1;
      end
    end
  end

  always_comb begin
    AST_ARB_WITHIN_REQ: assert ((gnt & ~req) == '0); // R6
  end
endmodule

// File: rtl/vs_iter.sv
module vs_iter #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int NN = N * N
) (
  input  logic [NN-1:0]   req,
  input  logic [N-1:0]    in_free,
  input  logic [N-1:0]    out_free,
  input  logic [N*IW-1:0] gptr,
  input  logic [N*IW-1:0] aptr,
  output logic [NN-1:0]   acc,
  output logic [N-1:0]    in_nxt,
  output logic [N-1:0]    out_nxt
);
  logic [N-1:0] gvec [N];  // gvec[j][i]: output j grants input i

  for (genvar j = 0; j < N; j++) begin : g_out
    logic [N-1:0] rq;
    always_comb begin
      for (int i = 0; i < N; i++)
        rq[i] = req[i*N+j] & in_free[i] & out_free[j];   // R9
    end
    vs_rr_arb #(.N(N)) u_grant (
      .req (rq),
      .ptr (gptr[j*IW +: IW]),
      .gnt (gvec[j])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [N-1:0] av;
    logic [N-1:0] ag;
    always_comb begin
      for (int j = 0; j < N; j++)
        av[j] = gvec[j][i] & in_free[i];
    end
    vs_rr_arb #(.N(N)) u_accept (
      .req (av),
      .ptr (aptr[i*IW +: IW]),
      .gnt (ag)
    );
    assign acc[i*N +: N] = ag;
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      in_nxt[i] = in_free[i] & ~(|acc[i*N +: N]);
    for (int j = 0; j < N; j++) begin
      out_nxt[j] = out_free[j];
      for (int i = 0; i < N; i++)
        if (acc[i*N+j]) out_nxt[j] = 1'b0;
    end
  end
endmodule

// File: rtl/vs_sched.sv
module vs_sched #(
  parameter int N     = 4,
  parameter int ITERS = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int NN = N * N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slot_go,
  input  logic [NN-1:0]   req,
  output logic [N-1:0]    xbar_en,
  output logic [N*IW-1:0] xbar_sel,
  output logic [N-1:0]    deq_vld,
  output logic [N*IW-1:0] deq_port
);
  logic [N*IW-1:0] gptr_q, aptr_q, gptr_d, aptr_d;
  logic [NN-1:0]   match_q, mfinal, acc0, left;

  // chained passes, each working on the ports the previous ones left free
  for (genvar t = 0; t < ITERS; t++) begin : g_it
    logic [N-1:0]  fin, fout, nin, nout;
    logic [NN-1:0] acc, mprev, macc;
    if (t == 0) begin : g_first
      assign fin   = '1;
      assign fout  = '1;
      assign mprev = '0;
    end else begin : g_next
      assign fin   = g_it[t-1].nin;
      assign fout  = g_it[t-1].nout;
      assign mprev = g_it[t-1].macc;
    end
    vs_iter #(.N(N)) u_pass (
      .req      (req),
      .in_free  (fin),
      .out_free (fout),
      .gptr     (gptr_q),
      .aptr     (aptr_q),
      .acc      (acc),
      .in_nxt   (nin),
      .out_nxt  (nout)
    );
    assign macc = mprev | acc;
  end

  assign mfinal = g_it[ITERS-1].macc;
  assign acc0   = g_it[0].acc;

  // pointer moves from first-pass acceptances only
  always_comb begin
    gptr_d = gptr_q;
    aptr_d = aptr_q;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (acc0[i*N+j]) begin
          gptr_d[j*IW +: IW] = IW'(vs_pkg::wrap_add(i, 1, N));
          aptr_d[i*IW +: IW] = IW'(vs_pkg::wrap_add(j, 1, N));
        end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      gptr_q  <= '0;
      aptr_q  <= '0;
    end else if (slot_go) begin
      match_q <= mfinal;
      gptr_q  <= gptr_d;
      aptr_q  <= aptr_d;
    end
  end

  // decode the registered pairing into port fields
  always_comb begin
    xbar_en  = '0;
    xbar_sel = '0;
    deq_vld  = '0;
    deq_port = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (match_q[i*N+j]) begin
          xbar_en[j]             = 1'b1;
          xbar_sel[j*IW +: IW]   = IW'(i);
          deq_vld[i]             = 1'b1;
          deq_port[i*IW +: IW]   = IW'(j);
        end
  end

  // free requests surviving the last pass
  always_comb begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        left[i*N+j] = req[i*N+j] & g_it[ITERS-1].nin[i] & g_it[ITERS-1].nout[j];
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    logic [N-1:0] row_q, col_q;
    always_comb begin
      for (int m = 0; m < N; m++) begin
        row_q[m] = match_q[k*N+m];
        col_q[m] = match_q[m*N+k];
      end
    end
    AST_ROW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_q)); // R3
    AST_COL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_q)); // R3
  end

  AST_ONLY_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    slot_go |=> ((match_q & ~$past(req)) == '0)); // R4

  AST_HOLD_BETWEEN_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_go |=> ($stable(match_q) && $stable(gptr_q) && $stable(aptr_q))); // R2

  if (ITERS >= N) begin : g_maxchk
    AST_NO_FREE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      slot_go |-> (left == '0)); // R5
  end
endmodule

// File: tb/sim_vs_sched.sv
module sim_vs_sched;
  localparam int N = 4;
  localparam int ITERS = 4;
  localparam int IW = 2;
  localparam int NN = N * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_go = 1'b0;
  logic [NN-1:0] req = '0;
  logic [N-1:0] xbar_en, deq_vld;
  logic [N*IW-1:0] xbar_sel, deq_port;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  int gp[N];
  int ap[N];
  logic [N-1:0] ex_en, ex_dv;
  logic [N*IW-1:0] ex_sel, ex_dp;

  always #2 clk = ~clk;

  vs_sched #(.N(N), .ITERS(ITERS)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_go(slot_go), .req(req),
    .xbar_en(xbar_en), .xbar_sel(xbar_sel), .deq_vld(deq_vld), .deq_port(deq_port)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    end
  endtask

  // arithmetic model of the passes for one slot
  task automatic model(input logic [NN-1:0] p);
    int inm[N];
    int outm[N];
    int gr[N];
    int ngp[N];
    int nap[N];
    for (int k = 0; k < N; k++) begin
      inm[k] = -1; outm[k] = -1; ngp[k] = gp[k]; nap[k] = ap[k];
    end
    for (int it = 0; it < ITERS; it++) begin
      for (int j = 0; j < N; j++) begin
        gr[j] = -1;
        if (outm[j] < 0)
          for (int k = 0; k < N; k++) begin
            int i;
            i = (gp[j] + k) % N;
            if (gr[j] < 0 && inm[i] < 0 && p[i*N+j]) gr[j] = i;
          end
      end
      for (int i = 0; i < N; i++) begin
        int s;
        s = -1;
        if (inm[i] < 0)
          for (int k = 0; k < N; k++) begin
            int j;
            j = (ap[i] + k) % N;
            if (s < 0 && gr[j] == i) s = j;
          end
        if (s >= 0) begin
          inm[i] = s;
          outm[s] = i;
          if (it == 0) begin
            ngp[s] = (i + 1) % N;
            nap[i] = (s + 1) % N;
          end
        end
      end
    end
    ex_en = '0; ex_dv = '0; ex_sel = '0; ex_dp = '0;
    for (int k = 0; k < N; k++) begin
      gp[k] = ngp[k];
      ap[k] = nap[k];
      if (outm[k] >= 0) begin
        ex_en[k] = 1'b1;
        ex_sel[k*IW +: IW] = IW'(outm[k]);
      end
      if (inm[k] >= 0) begin
        ex_dv[k] = 1'b1;
        ex_dp[k*IW +: IW] = IW'(inm[k]);
      end
    end
  endtask

  task automatic check_slot(input logic [NN-1:0] p);
    bit ok;
    // R6 R7 R8 R9: exact pairing against the model
    chk({xbar_en, xbar_sel, deq_vld, deq_port} == {ex_en, ex_sel, ex_dv, ex_dp},
        "R6 R7 R8 R9 pairing", {xbar_en, xbar_sel, deq_vld, deq_port}, {ex_en, ex_sel, ex_dv, ex_dp});
    // R3: both views agree and no port used twice
    ok = ($countones(xbar_en) == $countones(deq_vld));
    for (int j = 0; j < N; j++)
      if (xbar_en[j]) begin
        int s;
        s = int'(xbar_sel[j*IW +: IW]);
        if (!deq_vld[s] || int'(deq_port[s*IW +: IW]) != j) ok = 1'b0;
      end
    chk(ok, "R3 conflict", {xbar_en, deq_vld}, 64'($countones(xbar_en)));
    // R4: connected pairs were requested
    ok = 1'b1;
    for (int j = 0; j < N; j++)
      if (xbar_en[j] && !p[int'(xbar_sel[j*IW +: IW])*N + j]) ok = 1'b0;
    chk(ok, "R4 unrequested", xbar_en, p);
    // R5: no free pair with a request left
    ok = 1'b1;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (p[i*N+j] && !deq_vld[i] && !xbar_en[j]) ok = 1'b0;
    chk(ok, "R5 maximal", {xbar_en, deq_vld}, p);
    // R1: single request goes straight through
    if ($countones(p) == 1)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (p[i*N+j])
            chk(xbar_en == N'(1 << j) && deq_vld == N'(1 << i) &&
                int'(xbar_sel[j*IW +: IW]) == i && int'(deq_port[i*IW +: IW]) == j,
                "R1 single", {xbar_en, deq_vld}, 64'((1 << (j + N)) | (1 << i)));
  endtask

  task automatic do_slot(input logic [NN-1:0] p);
    @(negedge clk);
    req = p;
    slot_go = 1'b1;
    model(p);
    @(posedge clk);
    #1;
    check_slot(p);
  endtask

  initial begin
    #(4 * 190000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [N-1:0] h_en;
    logic [N*IW-1:0] h_sel;
    for (int k = 0; k < N; k++) begin gp[k] = 0; ap[k] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(xbar_en == '0 && deq_vld == '0, "R10 reset", {xbar_en, deq_vld}, 0);
    rst_n = 1'b1;

    // full request matrix from zero pointers: R10 pointers start at zero
    do_slot('1);
    chk(xbar_en == '1 && xbar_sel == 8'he4, "R10 R9 first slot", xbar_sel, 64'he4);

    // R2: hold with slot_go low while requests change
    h_en = xbar_en;
    h_sel = xbar_sel;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      slot_go = 1'b0;
      req = NN'(16'h8421 << c);
      @(posedge clk);
      #1;
      chk(xbar_en == h_en && xbar_sel == h_sel, "R2 hold", {xbar_en, xbar_sel}, {h_en, h_sel});
    end
    do_slot('1);  // pointers must be as left by the first slot

    // exhaustive sweep of request patterns, back to back slots
    for (int p = 0; p < (1 << NN); p++) do_slot(NN'(p));
    for (int p = (1 << NN) - 1; p >= 0; p -= 7) do_slot(NN'(p));

    summary();
    $finish;
  end
endmodule